// File: doc/BRIEF.md
# Serial Memory Low-Power Command Front End

This block is the command front end of a serial memory model that deals with the low-power instructions. It receives SPI mode 0 traffic: the host pulls chip select low and clocks bits in. The first eight bits form the instruction. The block tracks whether the device is in standby, in a timed transition, or in deep power-down. It uses that state to decide which instructions may pass to the rest of the device. When the release/signature instruction is given, the block returns an 8-bit signature on the serial output.

All SPI pins are oversampled in a single free-running system clock domain. The entry delay into deep power-down and the exit delay out of it are parameter counts of that clock. An external write/program/erase engine reports its activity on a busy input. The memory array and the status register live elsewhere.

Top module: `flash_pwr_front`

## Requirements
- R1: After reset the block is in standby: `dpd_flag` is 0, `sdo_en` is 0 and `cmd_ok` is 0.
- R2: Bits on `sdi` are taken MSB first at rising `sck` while `cs_n` is low. The first eight bits after `cs_n` falls are the instruction. In standby every complete instruction byte gives exactly one `cmd_ok` pulse. A transaction shorter than eight bits gives none.
- R3: The power-down opcode (default 0xB9) enters power-down only when three conditions hold: the device is in standby, `cs_n` rises after exactly 8 bits, and `busy` is low at that moment. In that case `dpd_flag` is still 0 TDP_CYC clock cycles after `cs_n` rises and is 1 by TDP_CYC+4 cycles.
- R4: If `cs_n` rises after any bit count other than 8 (for example 7 or 9), the power-down opcode is discarded and `dpd_flag` stays 0.
- R5: A power-down opcode completed while `busy` is high is rejected and `dpd_flag` stays 0. The byte is still accepted with `cmd_ok`.
- R6: During the entry delay no instruction is accepted (no `cmd_ok`), and the entry still completes.
- R7: While in power-down, every opcode other than the release opcode (default 0xAB) is ignored. This includes the power-down opcode and all write, program and erase codes. There is no `cmd_ok`, `sdo_en` stays 0 and `dpd_flag` stays 1.
- R8: In power-down the release opcode is accepted with `cmd_ok`. `dpd_flag` stays 1 for TRES_CYC cycles after `cs_n` rises and is 0 by TRES_CYC+4 cycles. Instructions sent during this exit delay are ignored.
- R9: After the release opcode, the next DUMMY_BYTES bytes (default 3) leave `sdo_en` low. The SIG byte then appears on `sdo`, MSB first, and repeats while `cs_n` stays low. `sdo` changes after falling `sck`, so each bit is valid at the next rising `sck`.
- R10: The release opcode sent in standby also returns the signature, and the device stays in standby.
- R11: `sdo_en` is 0 whenever `cs_n` has been high for 3 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, mode 0 |
| sdi | input | 1 | SPI serial data in |
| busy | input | 1 | High while an external write/program/erase cycle runs |
| sdo | output | 1 | Serial data out value |
| sdo_en | output | 1 | Output enable for `sdo`; low means high impedance |
| dpd_flag | output | 1 | High in deep power-down and during the exit delay |
| cmd_ok | output | 1 | One-cycle pulse when an instruction byte passes the mode gate |

## Verification
The bench builds the block with TDP_CYC and TRES_CYC set to 120 and the signature set to 0xC6. These values let a complete 8-bit transaction fit inside either delay, so commands sent during the entry and exit transitions can be driven and observed. The short delays also make it possible to sweep all 256 opcodes in both standby and power-down, and to sweep chip-select release over bit counts 1 through 12, with each case settling quickly. The signature 0xC6 mixes ones and zeros, so a reversed or shifted bit order shows up in the readback.

// File: rtl/fpf_pkg.sv
`timescale 1ns/1ps
package fpf_pkg;
  typedef enum logic [1:0] {
    M_STBY  = 2'd0,
    M_ENTER = 2'd1,
    M_DPD   = 2'd2,
    M_EXIT  = 2'd3
  } pm_mode_t;

  // Which instruction bytes may pass the mode gate.
  function automatic logic gate_open(pm_mode_t m, logic [7:0] op, logic [7:0] rel_op);
    return (m == M_STBY) || ((m == M_DPD) && (op == rel_op));
  endfunction

  // MSB-first bit selection for the signature stream.
  function automatic logic sig_bit(logic [7:0] sig, logic [2:0] idx);
    return sig[3'd7 - idx];
  endfunction
endpackage

// File: rtl/fpf_sync.sv
`timescale 1ns/1ps
module fpf_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic sdi,
  output logic cs_hi,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic sdi_s
);
  logic [2:0] cs_q;
  logic [2:0] sck_q;
  logic [1:0] sdi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q  <= 3'b111;
      sck_q <= 3'b000;
      sdi_q <= 2'b00;
    end else begin
      cs_q  <= {cs_q[1:0], cs_n};
      sck_q <= {sck_q[1:0], sck};
      sdi_q <= {sdi_q[0], sdi};
    end
  end

  assign cs_hi    = cs_q[1];
  assign cs_rise  = cs_q[1] & ~cs_q[2];
  assign sck_rise = sck_q[1] & ~sck_q[2] & ~cs_q[1];
  assign sck_fall = ~sck_q[1] & sck_q[2] & ~cs_q[1];
  assign sdi_s    = sdi_q[1];
endmodule

// File: rtl/fpf_shift_in.sv
`timescale 1ns/1ps
module fpf_shift_in #(
  parameter int DUMMY_BYTES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_hi,
  input  logic       sck_rise,
  input  logic       sdi_s,
  output logic       byte_done,
  output logic [7:0] opcode,
  output logic       at_boundary,
  output logic       data_phase,
  output logic [2:0] bit_idx
);
  localparam int BMAX = DUMMY_BYTES + 2;
  localparam int BW   = $clog2(BMAX + 1);

  logic [BW-1:0] byte_cnt;
  logic [6:0]    sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_cnt  <= '0;
      bit_idx   <= '0;
      sh        <= '0;
      opcode    <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (cs_hi) begin
        byte_cnt <= '0;
        bit_idx  <= '0;
      end else if (sck_rise) begin
        sh      <= {sh[5:0], sdi_s};
        bit_idx <= bit_idx + 3'd1;
        if (bit_idx == 3'd7) begin
          if (byte_cnt != BW'(BMAX)) byte_cnt <= byte_cnt + 1'b1;
          if (byte_cnt == '0) begin
            opcode    <= {sh, sdi_s};
            byte_done <= 1'b1;
          end
        end
      end
    end
  end

  assign at_boundary = (byte_cnt == BW'(1)) && (bit_idx == 3'd0);
  assign data_phase  = (byte_cnt >= BW'(DUMMY_BYTES + 1));
endmodule

// File: rtl/fpf_mode_ctrl.sv
`timescale 1ns/1ps
module fpf_mode_ctrl import fpf_pkg::*; #(
  parameter int          TDP_CYC  = 1000,
  parameter int          TRES_CYC = 1000,
  parameter logic [7:0]  DP_OP    = 8'hB9,
  parameter logic [7:0]  REL_OP   = 8'hAB
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_done,
  input  logic [7:0] opcode,
  input  logic       cs_rise,
  input  logic       at_boundary,
  input  logic       busy,
  output pm_mode_t   mode,
  output logic       accept,
  output logic       rd_start,
  output logic       entry_ev,
  output logic       exit_ev
);
  localparam int TMAX = (TDP_CYC > TRES_CYC) ? TDP_CYC : TRES_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  logic [TW-1:0] tmr;
  logic          rel_pend;

  assign accept   = byte_done && gate_open(mode, opcode, REL_OP);
  assign rd_start = accept && (opcode == REL_OP);
  assign entry_ev = cs_rise && (mode == M_STBY) && at_boundary && (opcode == DP_OP) && !busy;
  assign exit_ev  = cs_rise && (mode == M_DPD) && rel_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= M_STBY;
      tmr      <= '0;
      rel_pend <= 1'b0;
    end else begin
      if (cs_rise) rel_pend <= 1'b0;
      else if (accept && (mode == M_DPD)) rel_pend <= 1'b1;
      case (mode)
        M_STBY: if (entry_ev) begin
          mode <= M_ENTER;
          tmr  <= TW'(TDP_CYC - 1);
        end
        M_ENTER, M_EXIT: begin
          if (tmr == '0) mode <= (mode == M_ENTER) ? M_DPD : M_STBY;
          else tmr <= tmr - 1'b1;
        end
        M_DPD: if (exit_ev) begin
          mode <= M_EXIT;
          tmr  <= TW'(TRES_CYC - 1);
        end
        default: mode <= M_STBY;
      endcase
    end
  end
endmodule

// File: rtl/fpf_sig_out.sv
`timescale 1ns/1ps
module fpf_sig_out import fpf_pkg::*; #(
  parameter logic [7:0] SIG = 8'h13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_hi,
  input  logic       sck_fall,
  input  logic       rd_start,
  input  logic       data_phase,
  input  logic [2:0] bit_idx,
  output logic       sdo,
  output logic       sdo_en
);
  logic rd_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_on  <= 1'b0;
      sdo    <= 1'b0;
      sdo_en <= 1'b0;
    end else if (cs_hi) begin
      rd_on  <= 1'b0;
      sdo    <= 1'b0;
      sdo_en <= 1'b0;
    end else begin
      if (rd_start) rd_on <= 1'b1;
      if (sck_fall && rd_on && data_phase) begin
        sdo    <= sig_bit(SIG, bit_idx);
        sdo_en <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_pwr_front.sv
`timescale 1ns/1ps
module flash_pwr_front import fpf_pkg::*; #(
  parameter int         TDP_CYC     = 1000,
  parameter int         TRES_CYC    = 1000,
  parameter int         DUMMY_BYTES = 3,
  parameter logic [7:0] DP_OP       = 8'hB9,
  parameter logic [7:0] REL_OP      = 8'hAB,
  parameter logic [7:0] SIG         = 8'h13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic sdi,
  input  logic busy,
  output logic sdo,
  output logic sdo_en,
  output logic dpd_flag,
  output logic cmd_ok
);
  logic       cs_hi, cs_rise, sck_rise, sck_fall, sdi_s;
  logic       byte_done, at_boundary, data_phase, rd_start;
  logic       entry_ev, exit_ev;
  logic [7:0] opcode;
  logic [2:0] bit_idx;
  pm_mode_t   mode;

  fpf_sync u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .cs_hi(cs_hi), .cs_rise(cs_rise), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .sdi_s(sdi_s)
  );

  fpf_shift_in #(.DUMMY_BYTES(DUMMY_BYTES)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .sck_rise(sck_rise), .sdi_s(sdi_s),
    .byte_done(byte_done), .opcode(opcode), .at_boundary(at_boundary),
    .data_phase(data_phase), .bit_idx(bit_idx)
  );

  fpf_mode_ctrl #(.TDP_CYC(TDP_CYC), .TRES_CYC(TRES_CYC), .DP_OP(DP_OP), .REL_OP(REL_OP)) u_mode (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .opcode(opcode),
    .cs_rise(cs_rise), .at_boundary(at_boundary), .busy(busy),
    .mode(mode), .accept(cmd_ok), .rd_start(rd_start),
    .entry_ev(entry_ev), .exit_ev(exit_ev)
  );

  fpf_sig_out #(.SIG(SIG)) u_sig (
    .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .sck_fall(sck_fall),
    .rd_start(rd_start), .data_phase(data_phase), .bit_idx(bit_idx),
    .sdo(sdo), .sdo_en(sdo_en)
  );

  assign dpd_flag = (mode == M_DPD) || (mode == M_EXIT);
endmodule

// File: rtl/fpf_checker.sv
`timescale 1ns/1ps
module fpf_checker import fpf_pkg::*; #(
  parameter logic [7:0] REL_OP = 8'hAB
) (
  input logic       clk,
  input logic       rst_n,
  input pm_mode_t   mode,
  input logic       cmd_ok,
  input logic [7:0] opcode,
  input logic       cs_hi,
  input logic       sdo_en,
  input logic       dpd_flag,
  input logic       entry_ev,
  input logic       exit_ev
);
  assert_reset_standby_R1: assert property (@(posedge clk)
    !rst_n |=> (mode == M_STBY && !dpd_flag && !sdo_en));

  assert_enter_only_by_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_STBY && !entry_ev) |=> (mode == M_STBY));

  assert_enter_goes_to_dpd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ENTER) |=> (mode == M_ENTER || mode == M_DPD));

  assert_no_accept_in_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ENTER || mode == M_EXIT) |-> !cmd_ok);

  assert_dpd_lockout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DPD && cmd_ok) |-> (opcode == REL_OP));

  assert_dpd_leaves_via_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DPD && !exit_ev) |=> (mode == M_DPD));

  assert_hiz_when_deselected_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> !sdo_en);
endmodule

bind flash_pwr_front fpf_checker #(.REL_OP(REL_OP)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .cmd_ok(cmd_ok), .opcode(opcode),
  .cs_hi(cs_hi), .sdo_en(sdo_en), .dpd_flag(dpd_flag),
  .entry_ev(entry_ev), .exit_ev(exit_ev)
);

// File: tb/sim_flash_pwr_front.sv
`timescale 1ns/1ps
module sim_flash_pwr_front;
  localparam int         TDP  = 120;
  localparam int         TRES = 120;
  localparam int         HP   = 4;
  localparam logic [7:0] DP   = 8'hB9;
  localparam logic [7:0] REL  = 8'hAB;
  localparam logic [7:0] SIG  = 8'hC6;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, busy = 1'b0;
  logic sdo, sdo_en, dpd_flag, cmd_ok;
  int n_chk = 0, n_fail = 0, acc_cnt = 0;

  always #2.5 clk = ~clk;

  flash_pwr_front #(.TDP_CYC(TDP), .TRES_CYC(TRES), .SIG(SIG)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .busy(busy),
    .sdo(sdo), .sdo_en(sdo_en), .dpd_flag(dpd_flag), .cmd_ok(cmd_ok)
  );

  always @(posedge clk) if (cmd_ok) acc_cnt <= acc_cnt + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ncyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic so, output logic soe);
    sdi = b;
    ncyc(HP);
    so = sdo; soe = sdo_en;
    sck = 1'b1;
    ncyc(HP);
    sck = 1'b0;
  endtask

  // One transaction: cs low, nbits (opcode then zeros), cs high at a negedge.
  task automatic xact(input logic [7:0] op, input int nbits, output int en_seen);
    logic so, soe;
    en_seen = 0;
    ncyc(4);
    cs_n = 1'b0;
    ncyc(HP);
    for (int i = 0; i < nbits; i++) begin
      clk_bit((i < 8) ? op[7-i] : 1'b0, so, soe);
      if (soe) en_seen++;
    end
    ncyc(HP);
    cs_n = 1'b1;
  endtask

  task automatic readback(input string req);
    logic so, soe;
    logic [7:0] got;
    int en_dummy, miss, a;
    a = acc_cnt;
    ncyc(4);
    cs_n = 1'b0;
    ncyc(HP);
    for (int i = 0; i < 8; i++) clk_bit(REL[7-i], so, soe);
    en_dummy = 0;
    for (int i = 0; i < 24; i++) begin
      clk_bit(1'b0, so, soe);
      if (soe) en_dummy++;
    end
    chk({req, " release byte accepted"}, acc_cnt - a, 1);
    chk("R9 output disabled during dummy bytes", en_dummy, 0);
    for (int b = 0; b < 3; b++) begin
      got = '0; miss = 0;
      for (int i = 0; i < 8; i++) begin
        clk_bit(1'b0, so, soe);
        got = {got[6:0], so};
        if (!soe) miss++;
      end
      chk("R9 signature byte", got, SIG);
      chk("R9 output enabled during signature", miss, 0);
    end
    ncyc(HP);
    cs_n = 1'b1;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int a, en;
    ncyc(5);
    chk("R1 flag after reset", dpd_flag, 0);
    chk("R1 sdo_en after reset", sdo_en, 0);
    chk("R1 cmd_ok after reset", cmd_ok, 0);
    rst_n = 1'b1;
    ncyc(3);

    // R2: every opcode except power-down accepted once in standby
    for (int op = 0; op < 256; op++) begin
      if (op[7:0] == DP) continue;
      a = acc_cnt;
      xact(op[7:0], 8, en);
      ncyc(6);
      chk("R2 standby accept", acc_cnt - a, 1);
    end
    chk("R2 still standby", dpd_flag, 0);
    a = acc_cnt;
    xact(8'h06, 7, en);
    ncyc(6);
    chk("R2 short byte not accepted", acc_cnt - a, 0);

    // R3/R4: chip select released after 1..12 bits
    for (int n = 1; n <= 12; n++) begin
      xact(DP, n, en);
      ncyc(TDP);
      chk("R3 flag low before entry delay", dpd_flag, 0);
      ncyc(4);
      if (n == 8) chk("R3 valid entry", dpd_flag, 1);
      else chk("R4 off-boundary entry discarded", dpd_flag, 0);
      if (n == 8) begin
        xact(REL, 8, en);
        ncyc(TRES + 8);
        chk("R8 released", dpd_flag, 0);
      end
    end

    // R5: busy blocks entry
    busy = 1'b1;
    a = acc_cnt;
    xact(DP, 8, en);
    ncyc(TDP + 8);
    chk("R5 busy entry rejected", dpd_flag, 0);
    chk("R5 byte still accepted", acc_cnt - a, 1);
    busy = 1'b0;

    // R6: command during entry delay ignored
    xact(DP, 8, en);
    ncyc(2);
    a = acc_cnt;
    xact(8'h06, 8, en);
    ncyc(6);
    chk("R6 no accept during entry", acc_cnt - a, 0);
    ncyc(TDP + 8);
    chk("R6 entry completes", dpd_flag, 1);

    // R7: all non-release opcodes ignored in power-down
    for (int op = 0; op < 256; op++) begin
      if (op[7:0] == REL) continue;
      a = acc_cnt;
      xact(op[7:0], 16, en);
      ncyc(6);
      chk("R7 no accept in power-down", acc_cnt - a, 0);
      chk("R7 no output in power-down", en, 0);
      chk("R7 flag held", dpd_flag, 1);
    end

    // R8/R9: release with signature readback and exit window
    readback("R8");
    ncyc(TRES);
    chk("R8 flag held during exit delay", dpd_flag, 1);
    ncyc(4);
    chk("R8 flag clear after exit delay", dpd_flag, 0);
    chk("R11 output disabled after deselect", sdo_en, 0);

    // R8: commands during exit delay ignored
    xact(DP, 8, en);
    ncyc(TDP + 8);
    chk("R3 re-entry", dpd_flag, 1);
    xact(REL, 8, en);
    a = acc_cnt;
    xact(8'h06, 8, en);
    ncyc(6);
    chk("R8 no accept during exit", acc_cnt - a, 0);
    ncyc(TRES);
    chk("R8 exit completes", dpd_flag, 0);

    // R10: signature read in standby
    readback("R10");
    ncyc(TRES + 8);
    chk("R10 stays standby", dpd_flag, 0);
    chk("R11 output disabled while deselected", sdo_en, 0);

    report();
  end
endmodule